// File: doc/BRIEF.md
# Recursive Pyramid Wavelet Engine

This block computes a three-octave, one-dimensional discrete wavelet transform on a running stream of signed samples. It has one filter datapath: a row of multiply-accumulate taps, one per coefficient. Every octave shares it. Each use of the datapath is a job of two steps on one window of history. The low step takes the lowpass coefficient set and the high step takes the highpass set. The octave-one history is fed by the input stream. Each coarser history is fed by the lowpass results of the octave just finer than it. Octave j therefore produces one job every 2^j input samples, and coefficients from the different octaves leave the block interleaved in time.

When several octaves have a job pending, the coarsest one is served first. This keeps a coarse history from receiving a second new word before its window has been consumed. Samples are accepted while octave-one work is still running. A continuous stream therefore finishes in under two cycles per sample. The history before the first sample is taken as zero.

Both stream edges use valid/ready. An input sample transfers on a clock edge where `in_valid` and `in_ready` are both high. `in_ready` goes low while an octave-one job is waiting and has not yet started. An output beat transfers on an edge where `out_valid` and `out_ready` are both high. While `out_valid` is high and `out_ready` is low, the beat and its tags are held unchanged and the datapath stops. Because of this, output back-pressure eventually also lowers `in_ready`.

Top module: `rpa_dwt_engine`

## Requirements
- R1: After reset, `out_valid` is 0, `in_ready` is 1, and every filter history holds zero. Results after a reset therefore match a stream whose earlier samples are all zero.
- R2: Each even-numbered accepted sample n (counting from 1) produces one octave-1 highpass beat.
  - Its value is floor((g0·x[n] + g1·x[n-1] + g2·x[n-2] + g3·x[n-3]) / 2^15).
  - The default coefficients are g = (-4240, -7345, 27411, -15826).
- R3: The input of octave j (j = 2, 3) is the sequence of octave j-1 lowpass results.
  - A lowpass result is the same window formula with h = (15826, 27411, 7345, -4240).
  - On every second word of its input, octave j computes a lowpass and a highpass value from the same window.
- R4: `out_oct` carries the octave number 1, 2 or 3. `out_band` is 0 for lowpass and 1 for highpass. Only octave 3 emits lowpass beats.
- R5: For N accepted samples, with N a multiple of 8, the block emits N/2 octave-1 highpass beats, N/4 octave-2 highpass beats, and N/8 octave-3 beats of each band. Within each octave and band, beats come out in time order.
- R6: While `out_valid` is high and `out_ready` is low, `out_data`, `out_oct` and `out_band` stay stable. A blocked output eventually drives `in_ready` low.
- R7: Idle cycles between input samples do not change any output value.
- R8: With `in_valid` and `out_ready` held high, the span from the first sample transfer to the last output transfer is at most 2N+8 cycles.
- R9: With `out_ready` held high, every octave-3 lowpass beat is followed in the very next cycle by the octave-3 highpass beat of the same window.
- R10: Full-scale inputs of alternating sign give exact results at every octave, with no wrap-around.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input sample offered |
| in_ready | output | 1 | Input sample can be taken this cycle |
| in_data | input | 16 | Signed input sample |
| out_valid | output | 1 | Output beat present |
| out_ready | input | 1 | Consumer takes the output beat |
| out_data | output | 22 | Signed wavelet coefficient |
| out_oct | output | 2 | Octave number, 1 to 3 |
| out_band | output | 1 | 0 for lowpass, 1 for highpass |

## Verification
The main function is driven with these input patterns, each checked against an integer model of the cascaded, decimating filter bank:
- An impulse at the first sample exposes the tap order and the coefficient placement.
- An impulse at an odd position separates even-phase from odd-phase decimation.
- A constant input checks how DC settles in each octave.
- A ramp with idle gaps shows that stalls on the input side leave the history intact.
- Full-scale alternating values probe the width margin.
- A hashed pseudo-random sequence under random output stalls checks the interleaving and hold behaviour together.

A blocked-output run checks that back-pressure reaches the input. A reset taken in the middle of a stream checks that the histories are cleared.

// File: rtl/rpa_dwt_pkg.sv
package rpa_dwt_pkg;
  typedef enum logic {PH_LOW = 1'b0, PH_HIGH = 1'b1} rpa_phase_e;
  localparam logic BAND_LOW  = 1'b0;
  localparam logic BAND_HIGH = 1'b1;
endpackage

// File: rtl/rpa_tap_array.sv
module rpa_tap_array #(
  parameter int NTAP = 4,
  parameter int SW   = 22,
  parameter int CW   = 16,
  parameter int FRAC = 15
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NTAP-1:0][SW-1:0]  win,
  input  logic [NTAP*CW-1:0]       coef,
  output logic [SW-1:0]            y
);
  localparam int PW = SW + CW;
  localparam int AW = PW + $clog2(NTAP) + 1;

  logic signed [AW-1:0] prod [NTAP];
  logic signed [AW-1:0] acc;
  logic signed [AW-1:0] shifted;

  generate
    for (genvar k = 0; k < NTAP; k++) begin : g_tap
      logic signed [PW-1:0] p;
      assign p       = $signed(win[k]) * $signed(coef[k*CW +: CW]);
      assign prod[k] = AW'(p);
    end
  endgenerate

  always_comb begin
    acc = '0;
    for (int k = 0; k < NTAP; k++) acc = acc + prod[k];
  end

  assign shifted = acc >>> FRAC;
  assign y       = shifted[SW-1:0];

  // R10
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    shifted == AW'($signed(y)));
endmodule

// File: rtl/rpa_octave_store.sv
module rpa_octave_store #(
  parameter int NOCT = 3,
  parameter int NTAP = 4,
  parameter int SW   = 22
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic [NOCT-1:0]                    push,
  input  logic [NOCT-1:0][SW-1:0]            push_val,
  output logic [NOCT-1:0][NTAP-1:0][SW-1:0]  lines
);
  generate
    for (genvar j = 0; j < NOCT; j++) begin : g_line
      logic [NTAP-1:0][SW-1:0] taps;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       taps <= '0;
        else if (push[j]) taps <= {taps[NTAP-2:0], push_val[j]};
      end
      assign lines[j] = taps;
    end
  endgenerate
endmodule

// File: rtl/rpa_scheduler.sv
module rpa_scheduler
  import rpa_dwt_pkg::*;
#(
  parameter int NOCT = 3,
  parameter int OCTW = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             advance,
  input  logic [NOCT-1:0]  push,
  output logic             fire_low,
  output logic             fire_high,
  output logic [OCTW-1:0]  pick,
  output logic [OCTW-1:0]  cur,
  output logic [NOCT-1:0]  pend
);
  rpa_phase_e      phase;
  logic [NOCT-1:0] par;

  // coarsest pending octave wins
  always_comb begin
    pick = '0;
    for (int j = 0; j < NOCT; j++)
      if (pend[j]) pick = OCTW'(j);
  end

  assign fire_low  = advance && (phase == PH_LOW) && (|pend);
  assign fire_high = advance && (phase == PH_HIGH);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= PH_LOW;
      cur   <= '0;
      pend  <= '0;
      par   <= '0;
    end else begin
      if (fire_low) begin
        phase <= PH_HIGH;
        cur   <= pick;
      end else if (fire_high) begin
        phase <= PH_LOW;
      end
      for (int j = 0; j < NOCT; j++) begin
        if (push[j]) par[j] <= ~par[j];
        if (push[j] && par[j])                   pend[j] <= 1'b1;
        else if (fire_low && pick == OCTW'(j))   pend[j] <= 1'b0;
      end
    end
  end

  generate
    for (genvar j = 0; j < NOCT; j++) begin : g_chk
      // R5
      overrun_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(push[j] && par[j] && pend[j]));
    end
  endgenerate
endmodule

// File: rtl/rpa_dwt_engine.sv
module rpa_dwt_engine
  import rpa_dwt_pkg::*;
#(
  parameter int NTAP = 4,
  parameter int NOCT = 3,
  parameter int DW   = 16,
  parameter int CW   = 16,
  parameter int FRAC = 15,
  parameter logic [NTAP*CW-1:0] LO_COEF = 64'hEF70_1CB1_6B13_3DD2,
  parameter logic [NTAP*CW-1:0] HI_COEF = 64'hC22E_6B13_E34F_EF70,
  localparam int GROW = $clog2(NTAP),
  localparam int SW   = DW + GROW * NOCT,
  localparam int OCTW = $clog2(NOCT + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [DW-1:0]    in_data,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [SW-1:0]    out_data,
  output logic [OCTW-1:0]  out_oct,
  output logic             out_band
);
  logic                              advance, accept;
  logic                              fire_low, fire_high;
  logic [OCTW-1:0]                   pick, cur;
  logic [NOCT-1:0]                   pend, push;
  logic [NOCT-1:0][SW-1:0]           push_val;
  logic [NOCT-1:0][NTAP-1:0][SW-1:0] lines;
  logic [NTAP-1:0][SW-1:0]           win_q, mac_win;
  logic [NTAP*CW-1:0]                coef_sel;
  logic [SW-1:0]                     y;

  assign advance  = !out_valid || out_ready;
  assign in_ready = !pend[0] || (fire_low && pick == '0);
  assign accept   = in_valid && in_ready;

  assign push[0]     = accept;
  assign push_val[0] = SW'($signed(in_data));

  generate
    for (genvar j = 1; j < NOCT; j++) begin : g_feed
      assign push[j]     = fire_low && (pick == OCTW'(j - 1));
      assign push_val[j] = y;
    end
  endgenerate

  rpa_scheduler #(.NOCT(NOCT), .OCTW(OCTW)) u_sched (
    .clk(clk), .rst_n(rst_n), .advance(advance), .push(push),
    .fire_low(fire_low), .fire_high(fire_high), .pick(pick), .cur(cur), .pend(pend)
  );

  rpa_octave_store #(.NOCT(NOCT), .NTAP(NTAP), .SW(SW)) u_store (
    .clk(clk), .rst_n(rst_n), .push(push), .push_val(push_val), .lines(lines)
  );

  assign mac_win  = fire_high ? win_q : lines[pick];
  assign coef_sel = fire_high ? HI_COEF : LO_COEF;

  rpa_tap_array #(.NTAP(NTAP), .SW(SW), .CW(CW), .FRAC(FRAC)) u_taps (
    .clk(clk), .rst_n(rst_n), .win(mac_win), .coef(coef_sel), .y(y)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        win_q <= '0;
    else if (fire_low) win_q <= lines[pick];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
      out_oct   <= '0;
      out_band  <= BAND_LOW;
    end else if (fire_high) begin
      out_valid <= 1'b1;
      out_data  <= y;
      out_oct   <= cur + OCTW'(1);
      out_band  <= BAND_HIGH;
    end else if (fire_low && pick == OCTW'(NOCT - 1)) begin
      out_valid <= 1'b1;
      out_data  <= y;
      out_oct   <= pick + OCTW'(1);
      out_band  <= BAND_LOW;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  // R6
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_oct) && $stable(out_band));

  // R4
  lowpass_final_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_band == BAND_LOW |-> out_oct == OCTW'(NOCT));

  // R4
  oct_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> out_oct != '0 && out_oct <= OCTW'(NOCT));
endmodule

// File: tb/rpa_dwt_engine_test.sv
`timescale 1ns/1ps
module rpa_dwt_engine_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [15:0] in_data = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [21:0] out_data;
  logic [1:0]  out_oct;
  logic        out_band;

  always #2 clk = ~clk;

  rpa_dwt_engine uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .out_oct(out_oct), .out_band(out_band)
  );

  localparam int LOC[4] = '{15826, 27411, 7345, -4240};
  localparam int HIC[4] = '{-4240, -7345, 27411, -15826};

  // case table: pattern kind, amplitude, sample count, input gaps, output stall mode
  localparam int NCASE = 6;
  localparam int T_KIND [NCASE] = '{0,    1,    2,  3, 4, 5};
  localparam int T_AMP  [NCASE] = '{1000, 5000, 50, 0, 0, 3000};
  localparam int T_N    [NCASE] = '{32,   64,   32, 64, 64, 16};
  localparam int T_GAP  [NCASE] = '{0,    0,    1,  0, 1, 0};
  localparam int T_STL  [NCASE] = '{0,    0,    0,  1, 1, 2};

  int checks = 0, errors = 0;
  int cyc = 0;
  int stall_mode = 0, block_until = 0;
  int first_acc, last_out;
  logic [15:0] lfsr = 16'hACE1;
  bit mon_en = 0, hold_prev = 0, expect_h3 = 0;
  logic [21:0] hd; logic [1:0] ho; logic hb;

  longint mline[3][4];
  int     mcnt[3];
  longint refv[4][2][64], got[4][2][64];
  int     rcnt[4][2], gcnt[4][2];

  always @(posedge clk) cyc <= cyc + 1;

  always @(posedge clk) begin
    #1;
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    if (stall_mode == 0)      out_ready = 1'b1;
    else if (stall_mode == 1) out_ready = lfsr[0];
    else                      out_ready = (cyc >= block_until);
  end

  task automatic check(bit ok, string req, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int sample_of(int kind, int amp, int i);
    int h;
    case (kind)
      0: return (i == 0) ? amp : 0;
      1: return amp;
      2: return i * amp - 1000;
      3: return (i % 2 == 0) ? 32767 : -32768;
      4: begin h = ((i * 7919 + 13) * 31) ^ (i << 5); return (h & 16'hFFFF) - 32768; end
      default: return (i == 5) ? amp : 0;
    endcase
  endfunction

  function automatic longint filt(int j, bit hi);
    longint acc = 0;
    for (int k = 0; k < 4; k++) acc += longint'(hi ? HIC[k] : LOC[k]) * mline[j][k];
    return acc >>> 15;
  endfunction

  task automatic model_push(int v0);
    longint v = v0, lo, hi;
    for (int j = 0; j < 3; j++) begin
      for (int k = 3; k > 0; k--) mline[j][k] = mline[j][k-1];
      mline[j][0] = v;
      mcnt[j]++;
      if (mcnt[j] % 2 != 0) break;
      lo = filt(j, 0);
      hi = filt(j, 1);
      refv[j+1][1][rcnt[j+1][1]] = hi; rcnt[j+1][1]++;
      if (j == 2) begin refv[3][0][rcnt[3][0]] = lo; rcnt[3][0]++; end
      v = lo;
    end
  endtask

  // monitor: sampled at the falling edge, transfer completes at the next rising edge
  always @(negedge clk) if (mon_en) begin
    if (hold_prev)
      check(out_valid && out_data == hd && out_oct == ho && out_band == hb,
            "R6 hold", longint'($signed(out_data)), longint'($signed(hd)));
    if (expect_h3)
      check(out_valid && out_oct == 2'd3 && out_band == 1'b1, "R9 pairing", out_oct, 3);
    expect_h3 = 0;
    hold_prev = out_valid && !out_ready;
    hd = out_data; ho = out_oct; hb = out_band;
    if (out_valid && out_ready) begin
      check(out_oct >= 2'd1 && out_oct <= 2'd3 && (out_band || out_oct == 2'd3),
            "R4 tags", {out_oct, out_band}, 0);
      if (out_oct != 0 && gcnt[out_oct][out_band] < 64) begin
        got[out_oct][out_band][gcnt[out_oct][out_band]] = longint'($signed(out_data));
        gcnt[out_oct][out_band]++;
      end
      last_out = cyc;
      if (stall_mode == 0 && out_oct == 2'd3 && out_band == 1'b0) expect_h3 = 1;
    end
  end

  task automatic do_reset();
    in_valid = 0;
    rst_n = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    check(out_valid == 1'b0, "R1 out_valid", out_valid, 0);
    check(in_ready == 1'b1, "R1 in_ready", in_ready, 1);
  endtask

  task automatic drive(int kind, int amp, int n, bit gap);
    @(posedge clk); #1;
    for (int i = 0; i < n; i++) begin
      in_valid = 1;
      in_data  = 16'(sample_of(kind, amp, i));
      do @(negedge clk); while (!in_ready);
      if (first_acc < 0) first_acc = cyc;
      @(posedge clk); #1;
      if (gap && (i % 3 == 1)) begin in_valid = 0; @(posedge clk); #1; end
    end
    in_valid = 0;
  endtask

  task automatic run_case(int kind, int amp, int n, int gap, int stl);
    string req;
    int want;
    stall_mode = 0;
    do_reset();
    for (int j = 0; j < 3; j++) begin mcnt[j] = 0; for (int k = 0; k < 4; k++) mline[j][k] = 0; end
    for (int o = 0; o < 4; o++) for (int b = 0; b < 2; b++) begin rcnt[o][b] = 0; gcnt[o][b] = 0; end
    for (int i = 0; i < n; i++) model_push(sample_of(kind, amp, i));
    first_acc = -1; last_out = 0; hold_prev = 0; expect_h3 = 0;
    block_until = cyc + 100;
    stall_mode = stl;
    mon_en = 1;
    fork
      drive(kind, amp, n, gap[0]);
      begin
        if (stl == 2) begin
          repeat (60) @(negedge clk);
          check(out_valid && !in_ready, "R6 input blocked", {out_valid, in_ready}, 2);
        end
      end
    join
    repeat (200) @(negedge clk);
    mon_en = 0;
    for (int o = 1; o < 4; o++) for (int b = 0; b < 2; b++) begin
      want = (o == 3) ? n / 8 : ((b == 1) ? n / (1 << (o + 0)) / 2 * 1 : 0);
      if (o == 1 && b == 1) want = n / 2;
      if (o == 2 && b == 1) want = n / 4;
      check(gcnt[o][b] == want && rcnt[o][b] == want, "R5 count", gcnt[o][b], want);
      req = (kind == 3) ? "R10 value" : (gap != 0) ? "R7 value" : (o == 1) ? "R2 value" : "R3 value";
      if (kind == 0 || kind == 5) req = (o == 1) ? "R2 value" : "R1/R3 value";
      for (int i = 0; i < want && i < 64; i++)
        check(got[o][b][i] == refv[o][b][i], req, got[o][b][i], refv[o][b][i]);
    end
    if (stl == 0 && gap == 0)
      check(last_out - first_acc <= 2 * n + 8, "R8 span", last_out - first_acc, 2 * n + 8);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int c = 0; c < NCASE; c++)
      run_case(T_KIND[c], T_AMP[c], T_N[c], T_GAP[c], T_STL[c]);
    // directed: reset taken mid-stream with work pending, then an impulse must see zero history (R1)
    drive(1, 20000, 11, 0);
    run_case(0, 7000, 16, 0, 0);
    // directed: full scale with continuous flow checks R10 and the R9 pairing
    run_case(3, 0, 64, 0, 0);
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule